// File: doc/BRIEF.md
# Prioritized Exception Dispatcher for a 16-bit DSP Core

This block sits beside the sequencer of a small 16-bit DSP core and decides which exception, if any, the core should enter next. Exception causes raise single-cycle request pulses that are remembered in a pending mask. When the sequencer reaches an instruction boundary and asserts its check strobe, the block picks the highest-numbered cause that is currently allowed. On the next clock edge it emits a program-counter load with that cause's vector, pushes the interrupted PC onto the call stack and the interrupted status word onto the data stack, and hands back a status word with the matching enable bit cleared.

Cause 7 is the external interrupt from the host. It is not requested through the cause pulses. It arrives on its own request line, is accepted only while the status word's external-enable bit is set, and is not gated by the global enable. The block also keeps the control word, whose external-interrupt flag records a host request that has not yet been accepted. The stacks, the return-from-interrupt path and the decoder live elsewhere.

Top module: `dsp_exc_dispatch`

## Requirements
- R1: While reset is sampled high and in the first cycle after it, `pc_load` and `sr_load` are 1, `pc_new` is 0x0000, `sr_new` is 0x0A00 (global enable bit 9 and external enable bit 11 set), `cr_out` is 0x0804, and both push strobes are 0.
- R2: A pulse on `exc_req[n]` (n = 0..6) makes cause n pending, and it stays pending across any number of checks until cause n is dispatched.
- R3: A check dispatches the highest-numbered eligible pending cause among 7 down to 1.
- R4: Causes 1..6 are eligible only when `sr_in` bit 9 is 1. Cause 7 is eligible whatever the value of bit 9.
- R5: A dispatch taken on a check in cycle t gives, in cycle t+1 only, `pc_load`=1 with `pc_new` = 2 × cause, and `call_push`=1 with `call_data` = `pc_in` of cycle t. It also gives `data_push`=1 with `data_data` = `sr_in` of cycle t.
- R6: On a dispatch `sr_load`=1. `sr_new` is `sr_in` with bit 11 cleared for cause 7, and with bit 9 cleared for any other cause. All other bits are kept.
- R7: At most one cause is dispatched per check, and the dispatched cause stops being pending. Remaining causes go out on later checks, highest first.
- R8: A pulse on `ext_req` makes cause 7 pending and clears `cr_out` bit 11 only when `sr_in` bit 11 is 1. When that bit is 0 the cause is not made pending and `cr_out` bit 11 is set.
- R9: A check with no eligible pending cause produces no load and no push.
- R10: Cause 0 can be requested but is never dispatched.
- R11: A request for a cause that arrives in the same cycle as that cause's dispatch remains pending afterwards.
- R12: A check strobe with `insn_bound` low is ignored. No dispatch occurs, and pending causes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 7 | Request pulses for causes 0..6 |
| ext_req | input | 1 | External interrupt request pulse from the host |
| chk_stb | input | 1 | Dispatch check strobe |
| insn_bound | input | 1 | High at an instruction boundary |
| pc_in | input | 16 | Current program counter |
| sr_in | input | 16 | Current status word |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 16 | Vector or reset address |
| sr_load | output | 1 | Load `sr_new` into the status word |
| sr_new | output | 16 | Updated status word |
| call_push | output | 1 | Push strobe for the call stack |
| call_data | output | 16 | Return address to push |
| data_push | output | 1 | Push strobe for the data stack |
| data_data | output | 16 | Status word to push |
| cr_out | output | 16 | Control word with the external-interrupt flag at bit 11 |

## Verification
A corrupted pending mask shows only on a later check. A bit that is lost or stuck yields a missing, repeated or extra dispatch, so the bench issues repeated checks and drains every pending cause to expose it. A wrong priority or enable decision shows in `pc_new` and `sr_new` one cycle after the check. A bad control-word update shows on `cr_out` one cycle after the host request. The reference model compares all outputs on every cycle, so any divergence is reported at the first cycle in which it is visible.

// File: rtl/dsp_exc_pkg.sv
package dsp_exc_pkg;

    localparam int DATA_W      = 16;
    localparam int NUM_CAUSE   = 8;
    localparam int GIE_POS     = 9;
    localparam int EIE_POS     = 11;
    localparam int CR_EXT_POS  = 11;
    localparam logic [DATA_W-1:0] RESET_VECTOR = 16'h0000;
    localparam logic [DATA_W-1:0] SR_AT_RESET  = 16'h0A00;
    localparam logic [DATA_W-1:0] CR_AT_RESET  = 16'h0804;

    typedef struct packed {
        logic                valid;
        logic [2:0]          cause;
        logic [DATA_W-1:0]   ret_pc;
        logic [DATA_W-1:0]   saved_sr;
    } dispatch_t;

    function automatic logic [DATA_W-1:0] vector_of(input logic [2:0] cause);
        logic [DATA_W-1:0] v;
        v = '0;
        v[3:0] = {cause, 1'b0};
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] sr_after(input logic [DATA_W-1:0] sr,
                                                   input logic is_ext);
        logic [DATA_W-1:0] r;
        r = sr;
        if (is_ext) r[EIE_POS] = 1'b0;
        else        r[GIE_POS] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/exc_pending_mask.sv
module exc_pending_mask #(
    parameter int NC = dsp_exc_pkg::NUM_CAUSE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-2:0] req,
    input  logic          ext_set,
    input  logic [NC-1:0] clr_onehot,
    output logic [NC-1:0] pend
);
    logic [NC-1:0] pend_q;
    logic [NC-1:0] set_mask;

    always_comb begin
        set_mask = {ext_set, req};
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_onehot) | set_mask;
    end

    assign pend = pend_q;

    // R2: a pending cause not cleared this cycle stays pending
    p_hold_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (pend_q[1] && !clr_onehot[1]) |=> pend_q[1]);

    // R7: cleared cause drops unless re-requested
    p_clear_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_onehot[3] && !set_mask[3]) |=> !pend_q[3]);
endmodule

// File: rtl/exc_priority_pick.sv
module exc_priority_pick #(
    parameter int NC  = dsp_exc_pkg::NUM_CAUSE,
    parameter int IW  = $clog2(NC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] pend,
    input  logic          gie,
    input  logic          enable,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [NC-1:0] grant
);
    localparam int EXT = NC - 1;
    logic [NC-1:0] eligible;

    assign eligible[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 1; gi < NC; gi++) begin : g_elig
            if (gi == EXT) begin : g_ext
                assign eligible[gi] = pend[gi];
            end else begin : g_norm
                assign eligible[gi] = pend[gi] & gie;
            end
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        grant = '0;
        if (enable) begin
            for (int i = 1; i < NC; i++) begin
                if (eligible[i]) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end
            end
            if (found) grant[idx] = 1'b1;
        end
    end

    // R7: at most one cause granted per check
    p_single_grant_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R10: cause 0 is never granted
    p_no_cause0_r10: assert property (@(posedge clk) disable iff (rst)
        !grant[0]);
endmodule

// File: rtl/exc_dispatch_regs.sv
module exc_dispatch_regs
    import dsp_exc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  dispatch_t     disp,
    input  logic          ext_req,
    input  logic          eie_now,
    output logic          pc_load,
    output logic [DW-1:0] pc_new,
    output logic          sr_load,
    output logic [DW-1:0] sr_new,
    output logic          call_push,
    output logic [DW-1:0] call_data,
    output logic          data_push,
    output logic [DW-1:0] data_data,
    output logic [DW-1:0] cr_out
);
    localparam logic [2:0] EXT_CAUSE = 3'(NUM_CAUSE - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_load   <= 1'b1;
            pc_new    <= RESET_VECTOR;
            sr_load   <= 1'b1;
            sr_new    <= SR_AT_RESET;
            call_push <= 1'b0;
            call_data <= '0;
            data_push <= 1'b0;
            data_data <= '0;
        end else if (disp.valid) begin
            pc_load   <= 1'b1;
            pc_new    <= vector_of(disp.cause);
            sr_load   <= 1'b1;
            sr_new    <= sr_after(disp.saved_sr, disp.cause == EXT_CAUSE);
            call_push <= 1'b1;
            call_data <= disp.ret_pc;
            data_push <= 1'b1;
            data_data <= disp.saved_sr;
        end else begin
            pc_load   <= 1'b0;
            sr_load   <= 1'b0;
            call_push <= 1'b0;
            data_push <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          cr_out <= CR_AT_RESET;
        else if (ext_req) cr_out[CR_EXT_POS] <= !eie_now;
    end

    // R5: both stacks are pushed together
    p_push_pair_r5: assert property (@(posedge clk) disable iff (rst)
        call_push == data_push);
    // R5: a dispatch vector is even and inside the vector table
    p_vector_even_r5: assert property (@(posedge clk) disable iff (rst)
        call_push |-> (pc_load && !pc_new[0] && pc_new < 16));
    // R6: the right enable is dropped
    p_sr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        call_push |-> ((pc_new == 16'd14) ? !sr_new[EIE_POS] : !sr_new[GIE_POS]));
endmodule

// File: rtl/dsp_exc_dispatch.sv
module dsp_exc_dispatch
    import dsp_exc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NC = NUM_CAUSE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-2:0] exc_req,
    input  logic          ext_req,
    input  logic          chk_stb,
    input  logic          insn_bound,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] sr_in,
    output logic          pc_load,
    output logic [DW-1:0] pc_new,
    output logic          sr_load,
    output logic [DW-1:0] sr_new,
    output logic          call_push,
    output logic [DW-1:0] call_data,
    output logic          data_push,
    output logic [DW-1:0] data_data,
    output logic [DW-1:0] cr_out
);
    localparam int IW = $clog2(NC);

    logic [NC-1:0] pend;
    logic [NC-1:0] grant;
    logic          found;
    logic [IW-1:0] idx;
    logic          ext_accept;
    logic          check_ok;
    dispatch_t     disp;

    assign check_ok   = chk_stb & insn_bound;
    assign ext_accept = ext_req & sr_in[EIE_POS];

    exc_pending_mask #(.NC(NC)) u_mask (
        .clk(clk), .rst(rst), .req(exc_req), .ext_set(ext_accept),
        .clr_onehot(grant), .pend(pend)
    );

    exc_priority_pick #(.NC(NC), .IW(IW)) u_pick (
        .clk(clk), .rst(rst), .pend(pend), .gie(sr_in[GIE_POS]),
        .enable(check_ok), .found(found), .idx(idx), .grant(grant)
    );

    always_comb begin
        disp.valid    = found;
        disp.cause    = 3'(idx);
        disp.ret_pc   = pc_in;
        disp.saved_sr = sr_in;
    end

    exc_dispatch_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .disp(disp), .ext_req(ext_req),
        .eie_now(sr_in[EIE_POS]),
        .pc_load(pc_load), .pc_new(pc_new), .sr_load(sr_load), .sr_new(sr_new),
        .call_push(call_push), .call_data(call_data),
        .data_push(data_push), .data_data(data_data), .cr_out(cr_out)
    );

    // R12: no dispatch without a check at a boundary
    p_idle_no_push_r12: assert property (@(posedge clk) disable iff (rst)
        !check_ok |=> !call_push);
    // R8: accepted host request clears the control flag
    p_cr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ext_accept |=> !cr_out[CR_EXT_POS]);
    // R5: the return address is the PC of the check cycle
    p_ret_pc_r5: assert property (@(posedge clk) disable iff (rst)
        found |=> (call_data == $past(pc_in)));
    // R3: a dispatched cause was pending
    p_grant_pending_r3: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~pend) == '0));
endmodule

// File: tb/dsp_exc_dispatch_tb_top.sv
module dsp_exc_dispatch_tb_top;
    logic        clk = 0;
    logic        rst;
    logic [6:0]  exc_req;
    logic        ext_req, chk_stb, insn_bound;
    logic [15:0] pc_in, sr_in;
    logic        pc_load, sr_load, call_push, data_push;
    logic [15:0] pc_new, sr_new, call_data, data_data, cr_out;

    always #10 clk = ~clk;

    dsp_exc_dispatch dut_i (
        .clk(clk), .rst(rst), .exc_req(exc_req), .ext_req(ext_req),
        .chk_stb(chk_stb), .insn_bound(insn_bound), .pc_in(pc_in), .sr_in(sr_in),
        .pc_load(pc_load), .pc_new(pc_new), .sr_load(sr_load), .sr_new(sr_new),
        .call_push(call_push), .call_data(call_data),
        .data_push(data_push), .data_data(data_data), .cr_out(cr_out)
    );

    int n_chk = 0, n_fail = 0, cyc_cnt = 0;
    string tag = "R1";
    bit [7:0]  m_pend;
    bit [15:0] m_cr;
    bit        e_pcl, e_srl, e_push;
    bit [15:0] e_pcn, e_srn, e_cd, e_dd;
    bit        done = 0;

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 5000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run, exp completion");
            report();
        end
    end

    // Apply one cycle of stimulus, update model, compare after the edge.
    task automatic cyc(input bit r, input bit [6:0] req, input bit ext,
                       input bit chk, input bit bnd,
                       input bit [15:0] pc, input bit [15:0] sr);
        int win;
        bit mism;
        rst = r; exc_req = req; ext_req = ext; chk_stb = chk;
        insn_bound = bnd; pc_in = pc; sr_in = sr;
        if (r) begin
            m_pend = 0; m_cr = 16'h0804;
            e_pcl = 1; e_pcn = 0; e_srl = 1; e_srn = 16'h0A00; e_push = 0;
        end else begin
            win = -1;
            if (chk && bnd)
                for (int i = 7; i >= 1; i--)
                    if (win < 0 && m_pend[i] && (i == 7 || sr[9])) win = i;
            if (win >= 0) m_pend[win] = 0;
            m_pend[6:0] = m_pend[6:0] | req;
            if (ext) begin
                if (sr[11]) m_pend[7] = 1;
                m_cr[11] = !sr[11];
            end
            e_pcl = (win >= 0); e_srl = e_pcl; e_push = e_pcl;
            if (win >= 0) begin
                e_pcn = 16'(win * 2);
                e_srn = sr;
                if (win == 7) e_srn[11] = 0; else e_srn[9] = 0;
                e_cd = pc; e_dd = sr;
            end
        end
        @(posedge clk);
        @(negedge clk);
        mism = (pc_load !== e_pcl) || (sr_load !== e_srl) ||
               (call_push !== e_push) || (data_push !== e_push) || (cr_out !== m_cr);
        if (e_pcl && pc_new !== e_pcn) mism = 1;
        if (e_srl && sr_new !== e_srn) mism = 1;
        if (e_push && (call_data !== e_cd || data_data !== e_dd)) mism = 1;
        n_chk++;
        if (mism) begin
            n_fail++;
            $display("FAIL %s: got pcl=%0b pc=%h srl=%0b sr=%h push=%0b/%0b cd=%h dd=%h cr=%h exp pcl=%0b pc=%h srl=%0b sr=%h push=%0b cd=%h dd=%h cr=%h",
                     tag, pc_load, pc_new, sr_load, sr_new, call_push, data_push,
                     call_data, data_data, cr_out, e_pcl, e_pcn, e_srl, e_srn,
                     e_push, e_cd, e_dd, m_cr);
        end
    endtask

    task automatic idle(input bit [15:0] sr);
        cyc(0, 7'h0, 0, 0, 1, 16'h0100, sr);
    endtask

    initial begin
        @(negedge clk);
        tag = "R1";
        cyc(1, 0, 0, 0, 0, 16'h0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0, 16'h0);
        cyc(0, 0, 0, 0, 0, 16'h0, 16'h0A00);
        // R9: check with empty mask
        tag = "R9";
        cyc(0, 0, 0, 1, 1, 16'h0040, 16'h0A00);
        // R5 R6: single cause 3
        tag = "R5_R6";
        cyc(0, 7'b0001000, 0, 0, 1, 16'h0041, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h1234, 16'h0A5C);
        idle(16'h0A00);
        // R4 R2: cause 2 masked, held, later taken
        tag = "R4_R2";
        cyc(0, 7'b0000100, 0, 0, 1, 16'h0050, 16'h0800);
        cyc(0, 0, 0, 1, 1, 16'h0051, 16'h0800);
        cyc(0, 0, 0, 1, 1, 16'h0052, 16'h0800);
        tag = "R2";
        cyc(0, 0, 0, 1, 1, 16'h0053, 16'h0A01);
        // R3 R7: causes 1,5,6 drained in order
        tag = "R3_R7";
        cyc(0, 7'b1100010, 0, 0, 1, 16'h0060, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0061, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0062, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0063, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0064, 16'h0A00);
        // R8: external refused, flag set; check does nothing
        tag = "R8";
        cyc(0, 0, 1, 0, 1, 16'h0070, 16'h0200);
        cyc(0, 0, 0, 1, 1, 16'h0071, 16'h0A00);
        // R8 R4 R6: external accepted, taken with global enable off
        tag = "R8_R4";
        cyc(0, 0, 1, 0, 1, 16'h0072, 16'h0800);
        tag = "R4_R6";
        cyc(0, 0, 0, 1, 1, 16'hBEEF, 16'h0800);
        // R3: external beats cause 4
        tag = "R3";
        cyc(0, 7'b0010000, 1, 0, 1, 16'h0080, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0081, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0082, 16'h0A00);
        // R10: cause 0 never dispatched
        tag = "R10";
        cyc(0, 7'b0000001, 0, 1, 1, 16'h0090, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0091, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h0092, 16'h0A00);
        // R12: check without boundary ignored, cause kept
        tag = "R12";
        cyc(0, 7'b0100000, 0, 0, 1, 16'h00A0, 16'h0A00);
        cyc(0, 0, 0, 1, 0, 16'h00A1, 16'h0A00);
        cyc(0, 0, 0, 1, 0, 16'h00A2, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h00A3, 16'h0A00);
        // R11: re-request during dispatch survives
        tag = "R11";
        cyc(0, 7'b0001000, 0, 0, 1, 16'h00B0, 16'h0A00);
        cyc(0, 7'b0001000, 0, 1, 1, 16'h00B1, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h00B2, 16'h0A00);
        cyc(0, 0, 0, 1, 1, 16'h00B3, 16'h0A00);
        // R11: external re-accepted while cause 7 dispatches
        cyc(0, 0, 1, 0, 1, 16'h00C0, 16'h0800);
        cyc(0, 0, 1, 1, 1, 16'h00C1, 16'h0800);
        cyc(0, 0, 0, 1, 1, 16'h00C2, 16'h0000);
        idle(16'h0A00);
        done = 1;
        report();
    end
endmodule